// File: doc/BRIEF.md
# Display Identification Channel Responder

This block is the display side of a two-wire identification channel. It watches the host's clock and data wires, which reach it as plain level inputs sampled on the system clock. From their level changes it finds bus start and stop conditions and the clock edges. It takes in a 7-bit device address and a direction bit, and answers only when the address is 0x50.

A write transfer carries one byte, which becomes the read pointer into a 256-byte identification store. A read transfer sends store bytes most significant bit first. The pointer steps forward after every byte fetched. It wraps at 128 unless the extended span input is set, in which case it runs over all 256 entries. System logic loads the store through a synchronous write port.

The responder's own data drive is released-high, and is wire-ANDed with the host data level. A 4-bit status word shows the stored line levels.

Top module: `disp_id_responder`

## Requirements
- R1: A data-line fall while the stored clock level is high is a START. A data-line rise while the clock is high is a STOP. Either one overrides the current phase from any phase and releases the responder data output (drives 1).
- R2: When the clock and data inputs both differ from their stored levels in the same sample, `dual_change_o` pulses high for one cycle. The event has no protocol effect, but the new levels are still stored.
- R3: After START, the first clock fall opens the address phase. Seven address bits are sampled MSB first on clock rises, and the direction bit is sampled on the eighth rise. On the eighth fall the responder drives data low (ACK) only if the address was 0x50. Otherwise it leaves data high (NAK) and stays idle until the next START.
- R4: The responder data output only goes low on a clock falling edge.
- R5: In a write (direction bit 0), the next 8 bits, MSB first, replace the read pointer, and the responder always ACKs that byte.
- R6: In a read (direction bit 1), the bit 7 of the byte at the pointer is driven on the clock fall that ends the ACK slot, and each later bit is driven on the next fall. After bit 0 the line is released and the host's bit is sampled on the next rise. A host ACK (0) starts the next byte. A host NAK (1) returns to idle.
- R7: Each byte fetch post-increments the pointer. With `ext_span_i` = 0 the pointer wraps from 127 to 0.
- R8: With `ext_span_i` = 1 the pointer runs over 256 entries, so 127 is followed by 128.
- R9: `status_o` bit 3 = stored host data AND responder data, bit 2 = stored host clock, bit 1 = stored host data, bit 0 = stored host clock. The stored levels follow the pins one cycle late.
- R10: During reset the stored clock and data levels, the responder data, the ACK flag and the direction flag are 1, the pointer is 0, and the sequencer is idle. So `status_o` = 4'hF.
- R11: While `disable_i` is 1 the sequencer is held idle and the responder data output stays at 1.
- R12: A store write with `mem_we_i` = 1 updates the entry at `mem_waddr_i` at that clock edge, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk_i | input | 1 | Host clock wire level |
| line_dat_i | input | 1 | Host data wire level |
| disable_i | input | 1 | Holds the responder idle and released |
| ext_span_i | input | 1 | Pointer spans 256 entries instead of 128 |
| mem_we_i | input | 1 | Store write enable |
| mem_waddr_i | input | 8 | Store write address |
| mem_wdata_i | input | 8 | Store write data |
| mon_dat_o | output | 1 | Responder data drive, 1 = released |
| status_o | output | 4 | Packed line status word |
| dual_change_o | output | 1 | One-cycle flag: both wires changed in one sample |

## Verification
The bench drives whole transfers on the wires. It uses a pointer write followed by a repeated START and a multi-byte read, reads that cross the 127 boundary with each setting of the span input, and a wrong address. It also aborts a read with a STOP while the responder holds data low, changes both wires in one sample, and runs a transfer while disabled. The boundary reads separate the 7-bit wrap from the 8-bit span. The wrong address and the disabled transfer must both show a NAK, but for different reasons. The abort shows that STOP overrides a byte in progress, and the double change shows that no START or STOP is inferred from it.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;

    typedef enum logic [2:0] {
        PH_START,
        PH_ADDR,
        PH_DIR,
        PH_RX,
        PH_TX,
        PH_HOST_ACK,
        PH_MON_ACK,
        PH_IDLE
    } phase_e;

    typedef struct packed {
        logic clk_lvl;
        logic dat_lvl;
    } line_t;

    typedef struct packed {
        logic clk_fall;
        logic clk_rise;
        logic start;
        logic stop;
        logic dual;
    } line_ev_t;

    function automatic logic [3:0] pack_status(line_t lv, logic mon);
        return {lv.dat_lvl & mon, lv.clk_lvl, lv.dat_lvl, lv.clk_lvl};
    endfunction

endpackage

// File: rtl/disp_id_line.sv
module disp_id_line
    import disp_id_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_in,
    input  logic     dat_in,
    output line_t    lvl_o,
    output line_ev_t ev_o
);
    line_t lvl_q;
    logic  c_chg;
    logic  d_chg;

    assign c_chg = clk_in != lvl_q.clk_lvl;
    assign d_chg = dat_in != lvl_q.dat_lvl;

    always_comb begin
        ev_o          = '0;
        ev_o.dual     = c_chg & d_chg;
        ev_o.clk_fall = c_chg & ~d_chg & ~clk_in;
        ev_o.clk_rise = c_chg & ~d_chg & clk_in;
        ev_o.start    = d_chg & ~c_chg & lvl_q.clk_lvl & ~dat_in;
        ev_o.stop     = d_chg & ~c_chg & lvl_q.clk_lvl & dat_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '{clk_lvl: 1'b1, dat_lvl: 1'b1};
        end else begin
            lvl_q <= '{clk_lvl: clk_in, dat_lvl: dat_in};
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/disp_id_mem.sv
module disp_id_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/disp_id_fsm.sv
module disp_id_fsm
    import disp_id_pkg::*;
#(
    parameter int          OFS_W    = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ext_span,
    input  line_ev_t          ev,
    input  logic              dat_smp,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [OFS_W-1:0]  rd_addr,
    output logic              mon_o,
    output phase_e            phase_o
);
    localparam logic [CNT_W-1:0] TOP_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ADDR_TOP = CNT_W'(BYTE_W - 2);

    phase_e            phase_q;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic              ack_q;
    logic              dir_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              mon_q;
    logic [OFS_W-1:0]  ofs_inc;

    always_comb begin
        ofs_inc = ofs_q + 1'b1;
        if (!ext_span) begin
            ofs_inc[OFS_W-1] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            ack_q   <= 1'b1;
            dir_q   <= 1'b1;
            ofs_q   <= '0;
            mon_q   <= 1'b1;
        end else if (!en) begin
            phase_q <= PH_IDLE;
            mon_q   <= 1'b1;
        end else if (ev.start) begin
            phase_q <= PH_START;
            mon_q   <= 1'b1;
        end else if (ev.stop) begin
            phase_q <= PH_IDLE;
            mon_q   <= 1'b1;
        end else if (ev.clk_rise) begin
            case (phase_q)
                PH_ADDR, PH_RX: sh_q[bit_q] <= dat_smp;
                PH_DIR:         dir_q       <= dat_smp;
                PH_HOST_ACK:    ack_q       <= dat_smp;
                default: ;
            endcase
        end else if (ev.clk_fall) begin
            case (phase_q)
                PH_START: begin
                    phase_q <= PH_ADDR;
                    bit_q   <= ADDR_TOP;
                    sh_q    <= '0;
                end
                PH_ADDR: begin
                    if (bit_q != '0) begin
                        bit_q <= bit_q - 1'b1;
                    end else begin
                        ack_q   <= (sh_q[6:0] != DEV_ADDR);
                        phase_q <= PH_DIR;
                    end
                end
                PH_DIR: begin
                    phase_q <= PH_MON_ACK;
                    mon_q   <= ack_q;
                end
                PH_MON_ACK: begin
                    if (ack_q) begin
                        phase_q <= PH_IDLE;
                        mon_q   <= 1'b1;
                    end else if (dir_q) begin
                        phase_q <= PH_TX;
                        bit_q   <= TOP_BIT;
                        sh_q    <= rd_byte;
                        ofs_q   <= ofs_inc;
                        mon_q   <= rd_byte[BYTE_W-1];
                    end else begin
                        phase_q <= PH_RX;
                        bit_q   <= TOP_BIT;
                        sh_q    <= '0;
                        mon_q   <= 1'b1;
                    end
                end
                PH_RX: begin
                    if (bit_q != '0) begin
                        bit_q <= bit_q - 1'b1;
                    end else begin
                        ofs_q   <= OFS_W'(sh_q);
                        ack_q   <= 1'b0;
                        mon_q   <= 1'b0;
                        phase_q <= PH_MON_ACK;
                    end
                end
                PH_TX: begin
                    if (bit_q != '0) begin
                        bit_q <= bit_q - 1'b1;
                        mon_q <= sh_q[bit_q - 1'b1];
                    end else begin
                        phase_q <= PH_HOST_ACK;
                        mon_q   <= 1'b1;
                    end
                end
                PH_HOST_ACK: begin
                    if (ack_q) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        phase_q <= PH_TX;
                        bit_q   <= TOP_BIT;
                        sh_q    <= rd_byte;
                        ofs_q   <= ofs_inc;
                        mon_q   <= rd_byte[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = ofs_q;
    assign mon_o   = mon_q;
    assign phase_o = phase_q;
endmodule

// File: rtl/disp_id_responder.sv
module disp_id_responder
    import disp_id_pkg::*;
#(
    parameter int         OFS_W    = 8,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_clk_i,
    input  logic              line_dat_i,
    input  logic              disable_i,
    input  logic              ext_span_i,
    input  logic              mem_we_i,
    input  logic [OFS_W-1:0]  mem_waddr_i,
    input  logic [BYTE_W-1:0] mem_wdata_i,
    output logic              mon_dat_o,
    output logic [3:0]        status_o,
    output logic              dual_change_o
);
    line_t             lvl_w;
    line_ev_t          ev_w;
    logic [OFS_W-1:0]  rd_addr_w;
    logic [BYTE_W-1:0] rd_byte_w;
    phase_e            phase_w;
    logic              mon_w;
    logic              dual_q;

    disp_id_line u_line (
        .clk    (clk),
        .rst    (rst),
        .clk_in (line_clk_i),
        .dat_in (line_dat_i),
        .lvl_o  (lvl_w),
        .ev_o   (ev_w)
    );

    disp_id_mem #(.AW(OFS_W), .DW(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we_i),
        .waddr (mem_waddr_i),
        .wdata (mem_wdata_i),
        .raddr (rd_addr_w),
        .rdata (rd_byte_w)
    );

    disp_id_fsm #(.OFS_W(OFS_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (~disable_i),
        .ext_span (ext_span_i),
        .ev       (ev_w),
        .dat_smp  (line_dat_i),
        .rd_byte  (rd_byte_w),
        .rd_addr  (rd_addr_w),
        .mon_o    (mon_w),
        .phase_o  (phase_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dual_q <= 1'b0;
        end else begin
            dual_q <= ev_w.dual;
        end
    end

    assign mon_dat_o     = mon_w;
    assign status_o      = pack_status(lvl_w, mon_w);
    assign dual_change_o = dual_q;
endmodule

// File: rtl/disp_id_chk.sv
module disp_id_chk
    import disp_id_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       disable_i,
    input logic       line_clk_i,
    input logic       mon_dat_o,
    input logic [3:0] status_o,
    input logic       dual_change_o,
    input phase_e     phase_i
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (mon_dat_o && status_o == 4'hF && phase_i == PH_IDLE)); // R10

    AST_CLK_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> status_o[2] == $past(line_clk_i)); // R9

    AST_DUAL_BOTH_MOVED: assert property (@(posedge clk) disable iff (rst)
        dual_change_o |-> (status_o[2] != $past(status_o[2]) &&
                           status_o[1] != $past(status_o[1]))); // R2

    AST_DRIVE_ON_CLK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(mon_dat_o) |-> $fell(status_o[2])); // R4

    AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> (phase_i == PH_IDLE && mon_dat_o)); // R11
endmodule

bind disp_id_responder disp_id_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .disable_i     (disable_i),
    .line_clk_i    (line_clk_i),
    .mon_dat_o     (mon_dat_o),
    .status_o      (status_o),
    .dual_change_o (dual_change_o),
    .phase_i       (phase_w)
);

// File: tb/disp_id_responder_tb.sv
module disp_id_responder_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_clk_i = 1'b1;
    logic       line_dat_i = 1'b1;
    logic       disable_i = 1'b0;
    logic       ext_span_i = 1'b0;
    logic       mem_we_i = 1'b0;
    logic [7:0] mem_waddr_i = '0;
    logic [7:0] mem_wdata_i = '0;
    logic       mon_dat_o;
    logic [3:0] status_o;
    logic       dual_change_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    disp_id_responder u_dut (
        .clk           (clk),
        .rst           (rst),
        .line_clk_i    (line_clk_i),
        .line_dat_i    (line_dat_i),
        .disable_i     (disable_i),
        .ext_span_i    (ext_span_i),
        .mem_we_i      (mem_we_i),
        .mem_waddr_i   (mem_waddr_i),
        .mem_wdata_i   (mem_wdata_i),
        .mon_dat_o     (mon_dat_o),
        .status_o      (status_o),
        .dual_change_o (dual_change_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all): cycles=%0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #5;
    endtask

    task automatic set_clk(input logic v);
        line_clk_i = v;
        settle();
    endtask

    task automatic set_dat(input logic v);
        line_dat_i = v;
        settle();
    endtask

    task automatic bus_start();
        set_dat(1'b1);
        set_clk(1'b1);
        set_dat(1'b0);
        set_clk(1'b0);
    endtask

    task automatic bus_stop();
        set_clk(1'b0);
        set_dat(1'b0);
        set_clk(1'b1);
        set_dat(1'b1);
    endtask

    task automatic send_bit(input logic b);
        set_dat(b);
        set_clk(1'b1);
        set_clk(1'b0);
    endtask

    task automatic recv_bit(output logic b);
        set_dat(1'b1);
        set_clk(1'b1);
        b = status_o[3];
        set_clk(1'b0);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic dir, output logic ackb);
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(dir);
        recv_bit(ackb);
    endtask

    task automatic set_pointer(input logic [7:0] ofs);
        logic ackb;
        bus_start();
        addr_phase(7'h50, 1'b0, ackb);
        chk(ackb == 1'b0, "R3 own address write ACK", ackb, 0);
        send_byte(ofs);
        recv_bit(ackb);
        chk(ackb == 1'b0, "R5 pointer byte ACK", ackb, 0);
    endtask

    task automatic read_run(input int start, input int n, input logic ext);
        logic       ackb;
        logic [7:0] got;
        int         e;
        e = start;
        bus_start();
        addr_phase(7'h50, 1'b1, ackb);
        chk(ackb == 1'b0, "R3 own address read ACK", ackb, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(got);
            chk(got == pat(e), ext ? "R8 R6 byte in extended span" : "R7 R6 byte in 128 span",
                got, pat(e));
            e = ext ? ((e + 1) & 255) : ((e + 1) & 127);
            send_bit(k == n - 1);
        end
        chk(mon_dat_o == 1'b1, "R6 released after host NAK", mon_dat_o, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(status_o == 4'hF, "R10 status after reset", status_o, 4'hF);
        chk(mon_dat_o == 1'b1, "R10 data released after reset", mon_dat_o, 1);
        chk(dual_change_o == 1'b0, "R10 no dual flag after reset", dual_change_o, 0);
    endtask

    task automatic t_status();
        line_clk_i = 1'b0;
        chk(status_o == 4'hF, "R9 status lags pins", status_o, 4'hF);
        @(posedge clk);
        #1;
        chk(status_o == 4'b1010, "R9 clock low data high", status_o, 4'b1010);
        settle();
        set_dat(1'b0);
        chk(status_o == 4'b0000, "R9 both low", status_o, 4'b0000);
        set_dat(1'b1);
        set_clk(1'b1);
        chk(status_o == 4'hF, "R9 both high", status_o, 4'hF);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 256; i++) begin
            mem_we_i    = 1'b1;
            mem_waddr_i = 8'(i);
            mem_wdata_i = pat(i);
            @(posedge clk);
            #5;
        end
        mem_we_i = 1'b0;
    endtask

    task automatic t_write_then_read();
        set_pointer(8'h10);
        read_run(16, 4, 1'b0);
    endtask

    task automatic t_wrap_128();
        ext_span_i = 1'b0;
        set_pointer(8'd126);
        read_run(126, 3, 1'b0);
    endtask

    task automatic t_span_256();
        ext_span_i = 1'b1;
        set_pointer(8'd126);
        read_run(126, 3, 1'b1);
        ext_span_i = 1'b0;
    endtask

    task automatic t_mem_update();
        logic       ackb;
        logic [7:0] got;
        mem_we_i    = 1'b1;
        mem_waddr_i = 8'd5;
        mem_wdata_i = 8'hC3;
        @(posedge clk);
        #5;
        mem_we_i = 1'b0;
        set_pointer(8'd5);
        bus_start();
        addr_phase(7'h50, 1'b1, ackb);
        recv_byte(got);
        chk(got == 8'hC3, "R12 updated store entry", got, 8'hC3);
        send_bit(1'b1);
        bus_stop();
        mem_we_i    = 1'b1;
        mem_wdata_i = pat(5);
        @(posedge clk);
        #5;
        mem_we_i = 1'b0;
    endtask

    task automatic t_bad_address();
        logic ackb;
        logic b;
        bus_start();
        addr_phase(7'h51, 1'b1, ackb);
        chk(ackb == 1'b1, "R3 foreign address NAK", ackb, 1);
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            chk(b == 1'b1, "R3 silent after NAK", b, 1);
        end
        bus_stop();
    endtask

    task automatic t_stop_abort();
        logic ackb;
        set_pointer(8'd0);
        bus_start();
        addr_phase(7'h50, 1'b1, ackb);
        chk(mon_dat_o == pat(0)[7], "R6 bit 7 driven after ACK slot", mon_dat_o, pat(0)[7]);
        set_dat(1'b0);
        set_clk(1'b1);
        set_dat(1'b1);
        chk(mon_dat_o == 1'b1, "R1 STOP releases mid-byte", mon_dat_o, 1);
        chk(status_o[3] == 1'b1, "R1 line high after STOP", status_o[3], 1);
    endtask

    task automatic t_dual();
        line_clk_i = 1'b0;
        line_dat_i = 1'b0;
        @(posedge clk);
        #1;
        chk(dual_change_o == 1'b1, "R2 dual change flagged", dual_change_o, 1);
        @(posedge clk);
        #1;
        chk(dual_change_o == 1'b0, "R2 flag lasts one cycle", dual_change_o, 0);
        chk(status_o == 4'b0000, "R2 levels still stored", status_o, 0);
        set_clk(1'b1);
        chk(mon_dat_o == 1'b1, "R2 no START inferred", mon_dat_o, 1);
        set_dat(1'b1);
    endtask

    task automatic t_disabled();
        logic ackb;
        disable_i = 1'b1;
        bus_start();
        addr_phase(7'h50, 1'b1, ackb);
        chk(ackb == 1'b1, "R11 no ACK while disabled", ackb, 1);
        chk(mon_dat_o == 1'b1, "R11 data released while disabled", mon_dat_o, 1);
        bus_stop();
        disable_i = 1'b0;
        settle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #5;
        t_reset();
        rst = 1'b0;
        settle();
        t_preload();
        t_status();
        t_write_then_read();
        t_wrap_128();
        t_span_256();
        t_mem_update();
        t_bad_address();
        t_stop_abort();
        t_dual();
        t_disabled();
        t_write_then_read();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule